// File: doc/BRIEF.md
# Gated Event Timer with Toggle Gate

This block is a 16-bit up-counter whose advance is qualified by a gate. On each cycle where the count-enable tick is high, the counter either steps unconditionally or, when gating is enabled, steps only while the effective gate is active. The gate is picked from four inputs: an external pin, a wrap pulse from a small built-in 8-bit period timer, and two comparator outputs. The picked input can be inverted, is synchronised, and can be routed through a toggle stage. In toggle mode one whole gate period (rising edge to rising edge) opens the counter, instead of a single high level.

Software-facing access is an 8-bit control register with write and read-back, a write port for the period register of the companion timer, and direct load and read of the counter. A one-cycle overflow pulse marks the wrap of the counter. The current effective gate level is visible on a status output.

Control register layout: bits [1:0] gate source select, bit 5 toggle mode, bit 6 gate polarity invert, bit 7 gate enable. Bits [4:2] are stored and read back with no effect.

Top module: `gated_timer`

## Requirements
- R1: After reset the counter reads 0000h, the overflow pulse is 0, the gate status is 0 and the control register reads 00h.
- R2: With control bit 7 clear, the counter increments by one on every cycle where tickEn is high, whatever the gate inputs do.
- R3: With control bit 7 set and bits [1:0]=00, bit 5 and bit 6 clear, the counter increments on tick cycles only while gatePin is high; gateVal follows gatePin with a latency of two clock edges.
- R4: Control bit 6 set inverts the selected gate source, so a high gatePin closes the gate and a low one opens it.
- R5: Control bits [1:0] pick the source: 00 gatePin, 01 the period-timer wrap pulse, 10 cmp1Out, 11 cmp2Out; the sources not picked have no effect on gateVal or on counting.
- R6: With control bit 5 set, the effective gate changes state on each rising edge of the polarity-adjusted, synchronised source and keeps its state across falling edges, three edges after the source rises.
- R7: While control bit 5 is clear the toggle stage is held at 0, so setting bit 5 while the source is already high gives an effective gate of 0 and no counting until the next rising edge.
- R8: A write to the period register also clears the period timer; the period timer then advances on each tick from 0 up to the period value, wraps to 0 on the following tick and emits a one-cycle wrap pulse, i.e. one pulse per (period+1) ticks.
- R9: An increment from FFFFh yields 0000h and raises ovfPulse for exactly one cycle.
- R10: A counter write loads cntWdata on the next edge and wins over an increment in the same cycle; such a write never raises ovfPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-enable tick for counter and period timer |
| gatePin | input | 1 | External gate input (asynchronous) |
| cmp1Out | input | 1 | Comparator 1 output, gate source |
| cmp2Out | input | 1 | Comparator 2 output, gate source |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write data |
| ctrlRdata | output | 8 | Control register read-back |
| prdWr | input | 1 | Period register write strobe (also clears the period timer) |
| prdWdata | input | 8 | Period register write data |
| cntWr | input | 1 | Counter load strobe |
| cntWdata | input | 16 | Counter load value |
| cntValue | output | 16 | Current counter value |
| ovfPulse | output | 1 | One-cycle pulse on counter wrap |
| gateVal | output | 1 | Current effective gate level |

## Verification
The hardest situation to reach from the ports is the period-timer source under toggle mode, because its wrap pulse is internal and lasts a single cycle. The bench programs a period, which also restarts the period timer, holds the tick high for a known number of cycles and counts every change of gateVal, so the number of toggles pins down both the pulse rate and the toggle action. The second hard corner is re-arming toggle mode while the source is already high; the bench leaves the toggle stage at 1, clears and sets the mode bit with the pin high, and shows that the gate comes back closed and the counter stays still.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int CTRL_W   = 8;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 2;
  localparam int BIT_TGM  = 5;
  localparam int BIT_POL  = 6;
  localparam int BIT_GEN  = 7;
  localparam int NUM_SRC  = 1 << SEL_W;

  typedef struct packed {
    logic load;
    logic inc;
  } cntStrobe_t;
endpackage

// File: rtl/gtmr_period.sv
module gtmr_period #(
  parameter int PRD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             prdWr,
  input  logic [PRD_W-1:0] prdWdata,
  output logic             prdMatch
);
  logic [PRD_W-1:0] prdReg;
  logic [PRD_W-1:0] prdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdReg   <= '1;
      prdCnt   <= '0;
      prdMatch <= 1'b0;
    end else if (prdWr) begin
      prdReg   <= prdWdata;
      prdCnt   <= '0;
      prdMatch <= 1'b0;
    end else if (tickEn) begin
      if (prdCnt == prdReg) begin
        prdCnt   <= '0;
        prdMatch <= 1'b1;
      end else begin
        prdCnt   <= prdCnt + 1'b1;
        prdMatch <= 1'b0;
      end
    end else begin
      prdMatch <= 1'b0;
    end
  end

  AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    prdMatch |-> (prdCnt == '0)); // R8
  AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (prdMatch && prdReg != '0) |=> !prdMatch); // R8
endmodule

// File: rtl/gtmr_gate_ctrl.sv
module gtmr_gate_ctrl
  import gtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              gatePin,
  input  logic              prdMatch,
  input  logic              cmp1Out,
  input  logic              cmp2Out,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              cntWr,
  output logic [CTRL_W-1:0] ctrlRdata,
  output cntStrobe_t        strobe,
  output logic              gateVal
);
  logic [CTRL_W-1:0]      ctrlQ;
  logic [SEL_W-1:0]       selQ;
  logic                   tgmQ, polQ, genQ;
  logic [NUM_SRC-1:0]     srcVec;
  logic                   selGate, polGate;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncGate, prevGate, riseGate;
  logic                   tffQ, effGate;

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= ctrlWdata;
  end

  assign selQ      = ctrlQ[SEL_LSB +: SEL_W];
  assign tgmQ      = ctrlQ[BIT_TGM];
  assign polQ      = ctrlQ[BIT_POL];
  assign genQ      = ctrlQ[BIT_GEN];
  assign ctrlRdata = ctrlQ;

  // source order is the select encoding
  assign srcVec  = {cmp2Out, cmp1Out, prdMatch, gatePin};
  assign selGate = srcVec[selQ];
  assign polGate = selGate ^ polQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], polGate};
  end

  assign syncGate = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevGate <= 1'b0;
    else       prevGate <= syncGate;
  end

  assign riseGate = syncGate & ~prevGate;

  always_ff @(posedge clk) begin
    if (!rstN || !tgmQ) tffQ <= 1'b0;
    else if (riseGate)  tffQ <= ~tffQ;
  end

  assign effGate     = tgmQ ? tffQ : syncGate;
  assign gateVal     = effGate;
  assign strobe.load = cntWr;
  assign strobe.inc  = tickEn & (~genQ | effGate);

  AST_TOGGLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !tgmQ |=> !tffQ); // R7
  AST_TOGGLE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (tgmQ && !riseGate) |=> $stable(tffQ)); // R6
endmodule

// File: rtl/gtmr_count_dp.sv
module gtmr_count_dp
  import gtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntWdata,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovfPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntValue <= '0;
      ovfPulse <= 1'b0;
    end else if (strobe.load) begin
      cntValue <= cntWdata;
      ovfPulse <= 1'b0;
    end else if (strobe.inc) begin
      cntValue <= cntValue + 1'b1;
      ovfPulse <= (cntValue == CNT_MAX);
    end else begin
      ovfPulse <= 1'b0;
    end
  end

  AST_WRITE_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cntValue == $past(cntWdata) && !ovfPulse)); // R10
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cntValue == '0)); // R9
  AST_OVF_ONECYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse); // R9
  AST_HOLD_NO_INC: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.inc) |=> $stable(cntValue)); // R3
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              gatePin,
  input  logic              cmp1Out,
  input  logic              cmp2Out,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              prdWr,
  input  logic [PRD_W-1:0]  prdWdata,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntWdata,
  output logic [CNT_W-1:0]  cntValue,
  output logic              ovfPulse,
  output logic              gateVal
);
  logic       prdMatch;
  cntStrobe_t strobe;

  gtmr_period #(.PRD_W(PRD_W)) u_period (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .prdWr(prdWr), .prdWdata(prdWdata), .prdMatch(prdMatch)
  );

  gtmr_gate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .gatePin(gatePin), .prdMatch(prdMatch), .cmp1Out(cmp1Out), .cmp2Out(cmp2Out),
    .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata), .cntWr(cntWr),
    .ctrlRdata(ctrlRdata), .strobe(strobe), .gateVal(gateVal)
  );

  gtmr_count_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntWdata(cntWdata), .cntValue(cntValue), .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/gated_timer_tb.sv
module gated_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gatePin = 1'b0;
  logic        cmp1Out = 1'b0;
  logic        cmp2Out = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [7:0]  ctrlWdata = '0;
  logic [7:0]  ctrlRdata;
  logic        prdWr = 1'b0;
  logic [7:0]  prdWdata = '0;
  logic        cntWr = 1'b0;
  logic [15:0] cntWdata = '0;
  logic [15:0] cntValue;
  logic        ovfPulse;
  logic        gateVal;

  int checks = 0;
  int errors = 0;
  logic [15:0] expCnt = '0;

  gated_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gatePin(gatePin),
    .cmp1Out(cmp1Out), .cmp2Out(cmp2Out), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .prdWr(prdWr), .prdWdata(prdWdata), .cntWr(cntWr),
    .cntWdata(cntWdata), .cntValue(cntValue), .ovfPulse(ovfPulse), .gateVal(gateVal)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    ctrlWr = 1'b1; ctrlWdata = v;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic wrCnt(input logic [15:0] v);
    cntWr = 1'b1; cntWdata = v;
    @(negedge clk);
    cntWr = 1'b0;
  endtask

  task automatic testReset();
    check("R1 counter", cntValue, 16'h0000);
    check("R1 ovf", ovfPulse, 1'b0);
    check("R1 gateVal", gateVal, 1'b0);
    check("R1 ctrl", ctrlRdata, 8'h00);
  endtask

  task automatic testUngated();
    gatePin = 1'b0;
    wrCtrl(8'h1C);
    check("R1 ctrl readback", ctrlRdata, 8'h1C);
    ticks(10); expCnt += 10;
    check("R2 ungated count", cntValue, expCnt);
  endtask

  task automatic testPinGate();
    wrCtrl(8'h80);
    idle(3);
    ticks(10);
    check("R3 gate low holds", cntValue, expCnt);
    gatePin = 1'b1;
    idle(1);
    check("R3 latency one edge", gateVal, 1'b0);
    idle(1);
    check("R3 latency two edges", gateVal, 1'b1);
    ticks(7); expCnt += 7;
    check("R3 gate high counts", cntValue, expCnt);
  endtask

  task automatic testPolarity();
    wrCtrl(8'hC0);
    idle(3);
    check("R4 inverted high pin", gateVal, 1'b0);
    ticks(5);
    check("R4 inverted blocks", cntValue, expCnt);
    gatePin = 1'b0;
    idle(3);
    ticks(5); expCnt += 5;
    check("R4 inverted low counts", cntValue, expCnt);
  endtask

  task automatic testSelect();
    cmp1Out = 1'b1; cmp2Out = 1'b0; gatePin = 1'b0;
    wrCtrl(8'h82);
    idle(3);
    check("R5 sel=10 cmp1", gateVal, 1'b1);
    gatePin = 1'b1;
    idle(3);
    check("R5 pin ignored", gateVal, 1'b1);
    ticks(4); expCnt += 4;
    check("R5 cmp1 counts", cntValue, expCnt);
    wrCtrl(8'h83);
    idle(3);
    check("R5 sel=11 cmp2 low", gateVal, 1'b0);
    ticks(4);
    check("R5 cmp1 ignored", cntValue, expCnt);
    cmp2Out = 1'b1;
    idle(3);
    check("R5 sel=11 cmp2 high", gateVal, 1'b1);
    cmp1Out = 1'b0; cmp2Out = 1'b0; gatePin = 1'b0;
  endtask

  task automatic testToggle();
    wrCtrl(8'h80);
    idle(4);
    wrCtrl(8'hA0);
    idle(2);
    check("R6 toggle starts low", gateVal, 1'b0);
    gatePin = 1'b1;
    idle(2);
    check("R6 three-edge latency", gateVal, 1'b0);
    idle(1);
    check("R6 first rise opens", gateVal, 1'b1);
    gatePin = 1'b0;
    idle(4);
    check("R6 fall keeps state", gateVal, 1'b1);
    ticks(5); expCnt += 5;
    check("R6 counts over low pin", cntValue, expCnt);
    gatePin = 1'b1;
    idle(4);
    check("R6 second rise closes", gateVal, 1'b0);
    ticks(3);
    check("R6 closed holds", cntValue, expCnt);
    gatePin = 1'b0; idle(4);
    gatePin = 1'b1; idle(4);
    check("R6 third rise opens", gateVal, 1'b1);
    wrCtrl(8'h80);
    idle(3);
    check("R7 plain mode follows pin", gateVal, 1'b1);
    wrCtrl(8'hA0);
    idle(4);
    check("R7 re-arm with high source", gateVal, 1'b0);
    ticks(5);
    check("R7 no count after re-arm", cntValue, expCnt);
    gatePin = 1'b0;
  endtask

  task automatic testPeriod();
    int changes;
    logic last;
    wrCtrl(8'h21);
    idle(5);
    prdWr = 1'b1; prdWdata = 8'd3;
    @(negedge clk);
    prdWr = 1'b0;
    changes = 0;
    last = gateVal;
    tickEn = 1'b1;
    for (int i = 0; i < 46; i++) begin
      if (i == 40) tickEn = 1'b0;
      @(negedge clk);
      if (gateVal !== last) changes++;
      last = gateVal;
    end
    expCnt += 40;
    check("R8 wrap pulses in 40 ticks", changes, 10);
    check("R2 ungated during period test", cntValue, expCnt);
  endtask

  task automatic testWrap();
    wrCtrl(8'h00);
    tickEn = 1'b1;
    wrCnt(16'hFFFD);
    tickEn = 1'b0;
    expCnt = 16'hFFFD;
    check("R10 write beats increment", cntValue, expCnt);
    ticks(2);
    check("R9 reach FFFF", cntValue, 16'hFFFF);
    check("R9 no early ovf", ovfPulse, 1'b0);
    ticks(1);
    check("R9 wrap to zero", cntValue, 16'h0000);
    check("R9 ovf raised", ovfPulse, 1'b1);
    idle(1);
    check("R9 ovf one cycle", ovfPulse, 1'b0);
    wrCnt(16'hFFFF);
    tickEn = 1'b1;
    wrCnt(16'hFFFF);
    tickEn = 1'b0;
    check("R10 write at FFFF holds", cntValue, 16'hFFFF);
    check("R10 write gives no ovf", ovfPulse, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    testReset();
    testUngated();
    testPinGate();
    testPolarity();
    testSelect();
    testToggle();
    testPeriod();
    testWrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule